// File: doc/BRIEF.md
# ADAT Optical Frame Transmitter

This block turns a stream of 32-bit input words into a serial eight-channel optical audio line signal. It runs on the master clock. The first two words the block accepts configure it. The first sets the ratio of master clock to sample rate, which decides how many master clocks each line bit lasts. The second turns the two-way sample-multiplexing flag on or off. Every word after that is a sample: a 24-bit value held in the low bits of the word. Eight samples make up one frame.

Each group of eight samples is serialised into a 256-bit frame and sent out NRZI-coded on `tx_line`. Frames follow one another with no gap. If no new group has arrived by the time a frame ends, the previous samples are sent again. An end marker on the input stops the line after the frame in progress, and the block then waits for a new multiplier word.

The line is also delivered as 32-bit words for a serialiser placed further downstream. Each word holds 32 consecutive line levels, with its byte order reversed.

Top module: `adat_lightpipe_tx`

## Requirements
- R1: During and straight after reset, `tx_line` is 0, `word_valid` is 0 and `in_ready` is 1.
- R2: The first word accepted after reset or after a stop is the multiplier. The value 1024 gives 4 master clocks per line bit, and any other value gives 2. The second word accepted is the multiplexing setting: the value 2 turns the flag on, and any other value turns it off.
- R3: A frame is 256 bit periods long. It starts with 11 zero bits, then a 1 bit, then the 4-bit user nibble sent from its bit 3 down to bit 0. Channels 0 to 7 follow in order, each as six groups. Each group is a 1 marker bit followed by four sample bits, and the sample is sent from bit 23 down to bit 0. Bits 31:24 of a sample word are ignored.
- R4: A 1 bit toggles `tx_line` at the start of its bit period, and a 0 bit leaves it unchanged. While no frame is being sent, `tx_line` holds its value.
- R5: The first frame after configuration starts only once a complete group of eight samples has been accepted. An end marker that arrives before that point produces no line activity.
- R6: If no complete group is waiting when a frame ends, the next frame carries the same samples again.
- R7: The sent nibble is `user_bits`, except that its bit 1 is `user_bits[1]` OR the multiplexing flag. It is sampled each time a frame starts.
- R8: An end marker is an accepted beat with `in_end`=1, and its data is ignored. The frame in progress finishes, any partial group is discarded, the line stops, and `in_ready` returns to 1 to take a new multiplier word.
- R9: `in_ready` is 0 while a complete group waits for the next frame. It is also 0 from an accepted end marker until the final frame has finished.
- R10: During transmission, `word_valid` pulses for one cycle every 32 master clocks. Let V be the last 32 values of `tx_line`, with V[0] the value in the pulse cycle and V[31] the oldest. `word_data` is V with its four bytes in reversed order.
- R11: Consecutive frames follow each other with no gap, so bit k of frame f starts (f*256+k)*P master clocks after the start of frame 0. Here P is the number of master clocks per bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 32 | Configuration or sample word |
| in_valid | input | 1 | Input beat offered |
| in_end | input | 1 | Beat is an end marker |
| in_ready | output | 1 | Beat is taken at this edge when valid |
| user_bits | input | 4 | User nibble for each frame |
| tx_line | output | 1 | NRZI line output |
| word_data | output | 32 | Byte-reversed group of 32 line levels |
| word_valid | output | 1 | One-cycle strobe for word_data |

## Verification
The bench builds the block with its default parameters: eight channels of 24-bit samples, 32-bit words and an 11-bit sync run. At run time it drives the multiplier as 512, as 1024 and as an unlisted value, so both bit periods and the fallback can be observed. It decodes the NRZI line back into frame bits from the first toggle onward and compares every bit with a frame it builds itself from the sample table. This reaches the repeated-frame case, the end marker that arrives before the first frame, the stop after the current frame, and the multiplexing flag in the nibble. Each word strobe is checked against the line levels the bench itself saw.

// File: rtl/adat_tx_pkg.sv
package adat_tx_pkg;

    parameter int WORD_W    = 32;
    parameter int SAMPLE_W  = 24;
    parameter int CHANNELS  = 8;
    parameter int NIB_W     = 4;
    parameter int SYNC_LEN  = 11;
    parameter int SUB_W     = 2;
    parameter int SMUX_BIT  = 1;

    localparam int CNT_W        = $clog2(SYNC_LEN);
    localparam int MUL_WIDE     = 1024;
    localparam int SMUX_ON_CODE = 2;

    typedef enum logic [1:0] {
        IN_MUL,
        IN_SMUX,
        IN_RUN,
        IN_DRAIN
    } intake_st_e;

    typedef enum logic [2:0] {
        SEG_SYNC,
        SEG_HEAD,
        SEG_USER,
        SEG_MARK,
        SEG_DATA
    } seg_e;

    typedef struct packed {
        seg_e             seg;
        logic [CNT_W-1:0] cnt;
        logic [SUB_W-1:0] sub;
    } seq_pos_t;

    typedef struct packed {
        logic x4;
        logic smux;
    } cfg_t;

    localparam seq_pos_t POS_INIT = '{seg: SEG_SYNC, cnt: '0, sub: '0};

    function automatic logic [WORD_W-1:0] byte_rev(input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] r;
        for (int b = 0; b < WORD_W / 8; b++) begin
            r[b*8 +: 8] = w[(WORD_W/8 - 1 - b)*8 +: 8];
        end
        return r;
    endfunction

    function automatic logic [NIB_W-1:0] nib_build(input logic [NIB_W-1:0] u,
                                                   input logic smux);
        logic [NIB_W-1:0] r;
        r = u;
        r[SMUX_BIT] = u[SMUX_BIT] | smux;
        return r;
    endfunction

endpackage

// File: rtl/adat_cfg_intake.sv
module adat_cfg_intake
    import adat_tx_pkg::*;
#(
    parameter int CH = CHANNELS,
    parameter int SW = SAMPLE_W,
    parameter int WW = WORD_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WW-1:0]    in_data,
    input  logic             in_valid,
    input  logic             in_end,
    output logic             in_ready,
    input  logic             frame_take,
    input  logic             seq_active,
    input  logic             seq_halt,
    output cfg_t             cfg,
    output logic             stage_full,
    output logic [CH*SW-1:0] stage_flat,
    output logic             may_start,
    output logic             stop_req
);

    localparam int CH_W = (CH > 1) ? $clog2(CH) : 1;

    intake_st_e      st;
    logic [SW-1:0]   stage [CH];
    logic [CH_W-1:0] idx;
    logic            accept;

    assign in_ready  = (st == IN_MUL) || (st == IN_SMUX) || ((st == IN_RUN) && !stage_full);
    assign accept    = in_valid && in_ready;
    assign may_start = (st == IN_RUN);
    assign stop_req  = (st == IN_DRAIN);

    // channel 0 occupies the most significant slice of the flat vector
    for (genvar i = 0; i < CH; i++) begin : g_flat
        assign stage_flat[(CH-1-i)*SW +: SW] = stage[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= IN_MUL;
            cfg        <= '0;
            idx        <= '0;
            stage_full <= 1'b0;
            for (int i = 0; i < CH; i++) begin
                stage[i] <= '0;
            end
        end else begin
            case (st)
                IN_MUL: begin
                    if (accept && !in_end) begin
                        cfg.x4 <= (in_data == WW'(MUL_WIDE));
                        st     <= IN_SMUX;
                    end
                end
                IN_SMUX: begin
                    if (accept && !in_end) begin
                        cfg.smux   <= (in_data == WW'(SMUX_ON_CODE));
                        idx        <= '0;
                        stage_full <= 1'b0;
                        st         <= IN_RUN;
                    end
                end
                IN_RUN: begin
                    if (frame_take) begin
                        stage_full <= 1'b0;
                    end
                    if (accept) begin
                        if (in_end) begin
                            idx        <= '0;
                            stage_full <= 1'b0;
                            st         <= seq_active ? IN_DRAIN : IN_MUL;
                        end else begin
                            stage[idx] <= in_data[SW-1:0];
                            if (idx == CH_W'(CH-1)) begin
                                idx        <= '0;
                                stage_full <= 1'b1;
                            end else begin
                                idx <= idx + 1'b1;
                            end
                        end
                    end
                end
                IN_DRAIN: begin
                    if (seq_halt) begin
                        st <= IN_MUL;
                    end
                end
                default: st <= IN_MUL;
            endcase
        end
    end

endmodule

// File: rtl/adat_frame_seq.sv
module adat_frame_seq
    import adat_tx_pkg::*;
#(
    parameter int CH = CHANNELS,
    parameter int SW = SAMPLE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  cfg_t             cfg,
    input  logic [NIB_W-1:0] user_bits,
    input  logic             stage_full,
    input  logic [CH*SW-1:0] stage_flat,
    input  logic             may_start,
    input  logic             stop_req,
    output logic             frame_take,
    output logic             halt,
    output logic             active,
    output logic             line,
    output logic             line_nx
);

    localparam int PAY_W  = CH * SW;
    localparam int GROUPS = PAY_W / NIB_W;
    localparam int GRP_W  = $clog2(GROUPS);

    seq_pos_t         pos, pos_nx;
    logic [GRP_W-1:0] grp;
    logic [PAY_W-1:0] frame_buf, shreg, next_pay;
    logic [NIB_W-1:0] nib_sh;
    logic             last_sub, cur_bit, frame_end, start;

    assign last_sub  = (pos.sub == (cfg.x4 ? SUB_W'(3) : SUB_W'(1)));
    assign frame_end = active && last_sub && (pos.seg == SEG_DATA)
                     && (pos.cnt == CNT_W'(NIB_W-1)) && (grp == GRP_W'(GROUPS-1));
    assign start      = !active && may_start && stage_full;
    assign frame_take = start || (frame_end && !stop_req && stage_full);
    assign halt       = frame_end && stop_req;
    assign next_pay   = stage_full ? stage_flat : frame_buf;

    always_comb begin
        case (pos.seg)
            SEG_HEAD: cur_bit = 1'b1;
            SEG_USER: cur_bit = nib_sh[NIB_W-1];
            SEG_MARK: cur_bit = 1'b1;
            SEG_DATA: cur_bit = shreg[PAY_W-1];
            default:  cur_bit = 1'b0;
        endcase
    end

    assign line_nx = (active && (pos.sub == '0)) ? (line ^ cur_bit) : line;

    always_comb begin
        pos_nx = pos;
        if (!last_sub) begin
            pos_nx.sub = pos.sub + 1'b1;
        end else begin
            pos_nx.sub = '0;
            case (pos.seg)
                SEG_SYNC: begin
                    if (pos.cnt == CNT_W'(SYNC_LEN-1)) begin
                        pos_nx.seg = SEG_HEAD;
                        pos_nx.cnt = '0;
                    end else begin
                        pos_nx.cnt = pos.cnt + 1'b1;
                    end
                end
                SEG_HEAD: begin
                    pos_nx.seg = SEG_USER;
                    pos_nx.cnt = '0;
                end
                SEG_USER: begin
                    if (pos.cnt == CNT_W'(NIB_W-1)) begin
                        pos_nx.seg = SEG_MARK;
                        pos_nx.cnt = '0;
                    end else begin
                        pos_nx.cnt = pos.cnt + 1'b1;
                    end
                end
                SEG_MARK: begin
                    pos_nx.seg = SEG_DATA;
                    pos_nx.cnt = '0;
                end
                SEG_DATA: begin
                    if (pos.cnt == CNT_W'(NIB_W-1)) begin
                        pos_nx.seg = SEG_MARK;
                        pos_nx.cnt = '0;
                    end else begin
                        pos_nx.cnt = pos.cnt + 1'b1;
                    end
                end
                default: pos_nx = POS_INIT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            pos       <= POS_INIT;
            grp       <= '0;
            frame_buf <= '0;
            shreg     <= '0;
            nib_sh    <= '0;
            line      <= 1'b0;
        end else begin
            line <= line_nx;
            if (start) begin
                active    <= 1'b1;
                pos       <= POS_INIT;
                grp       <= '0;
                frame_buf <= stage_flat;
                shreg     <= stage_flat;
                nib_sh    <= nib_build(user_bits, cfg.smux);
            end else if (active) begin
                if (frame_end) begin
                    pos <= POS_INIT;
                    grp <= '0;
                    if (stop_req) begin
                        active <= 1'b0;
                    end else begin
                        frame_buf <= next_pay;
                        shreg     <= next_pay;
                        nib_sh    <= nib_build(user_bits, cfg.smux);
                    end
                end else begin
                    pos <= pos_nx;
                    if (last_sub) begin
                        if (pos.seg == SEG_USER) begin
                            nib_sh <= {nib_sh[NIB_W-2:0], 1'b0};
                        end
                        if (pos.seg == SEG_DATA) begin
                            shreg <= {shreg[PAY_W-2:0], 1'b0};
                            if (pos.cnt == CNT_W'(NIB_W-1)) begin
                                grp <= grp + 1'b1;
                            end
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/adat_word_pack.sv
module adat_word_pack
    import adat_tx_pkg::*;
#(
    parameter int WW = WORD_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          act,
    input  logic          line_nx,
    output logic [WW-1:0] word_data,
    output logic          word_valid
);

    localparam int CW = $clog2(WW);

    logic [WW-1:0] sh;
    logic [WW-1:0] sh_nx;
    logic [CW-1:0] cnt;

    assign sh_nx = {sh[WW-2:0], line_nx};

    always_ff @(posedge clk) begin
        if (rst) begin
            sh         <= '0;
            cnt        <= '0;
            word_data  <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= 1'b0;
            if (act) begin
                sh  <= sh_nx;
                cnt <= cnt + 1'b1;
                if (cnt == CW'(WW-1)) begin
                    word_data  <= byte_rev(sh_nx);
                    word_valid <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/adat_lightpipe_tx.sv
module adat_lightpipe_tx
    import adat_tx_pkg::*;
#(
    parameter int CH = CHANNELS,
    parameter int SW = SAMPLE_W,
    parameter int WW = WORD_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [WW-1:0] in_data,
    input  logic          in_valid,
    input  logic          in_end,
    output logic          in_ready,
    input  logic [3:0]    user_bits,
    output logic          tx_line,
    output logic [WW-1:0] word_data,
    output logic          word_valid
);

    cfg_t             cfg;
    logic             cfg_x4;
    logic             stage_full, may_start, stop_req;
    logic [CH*SW-1:0] stage_flat;
    logic             frame_take, seq_halt, seq_active, line_nx;

    assign cfg_x4 = cfg.x4;

    adat_cfg_intake #(.CH(CH), .SW(SW), .WW(WW)) u_intake (
        .clk        (clk),
        .rst        (rst),
        .in_data    (in_data),
        .in_valid   (in_valid),
        .in_end     (in_end),
        .in_ready   (in_ready),
        .frame_take (frame_take),
        .seq_active (seq_active),
        .seq_halt   (seq_halt),
        .cfg        (cfg),
        .stage_full (stage_full),
        .stage_flat (stage_flat),
        .may_start  (may_start),
        .stop_req   (stop_req)
    );

    adat_frame_seq #(.CH(CH), .SW(SW)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .cfg        (cfg),
        .user_bits  (user_bits),
        .stage_full (stage_full),
        .stage_flat (stage_flat),
        .may_start  (may_start),
        .stop_req   (stop_req),
        .frame_take (frame_take),
        .halt       (seq_halt),
        .active     (seq_active),
        .line       (tx_line),
        .line_nx    (line_nx)
    );

    adat_word_pack #(.WW(WW)) u_pack (
        .clk        (clk),
        .rst        (rst),
        .act        (seq_active),
        .line_nx    (line_nx),
        .word_data  (word_data),
        .word_valid (word_valid)
    );

endmodule

// File: rtl/adat_lightpipe_tx_chk.sv
module adat_lightpipe_tx_chk (
    input logic clk,
    input logic rst,
    input logic tx_line,
    input logic word_valid,
    input logic in_ready,
    input logic act,
    input logic halt,
    input logic mul_x4
);

    // R4: no line activity outside a frame
    a_r4_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !act |=> $stable(tx_line));

    // R2: a toggle is never followed by another one on the next clock
    a_r2_narrow_gap: assert property (@(posedge clk) disable iff (rst)
        (tx_line != $past(tx_line)) |=> $stable(tx_line));

    // R2: with the wide multiplier the line holds for a full 4-clock bit
    a_r2_wide_gap: assert property (@(posedge clk) disable iff (rst)
        (mul_x4 && (tx_line != $past(tx_line)))
        |=> $stable(tx_line) ##1 $stable(tx_line) ##1 $stable(tx_line));

    // R10: word strobe is a single-cycle pulse
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
        word_valid |=> !word_valid);

    // R10: words appear only while a frame is being sent
    a_r10_word_live: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> $past(act));

    // R8: after the final frame the input is open for a new multiplier
    a_r8_halt_ready: assert property (@(posedge clk) disable iff (rst)
        halt |=> in_ready);

endmodule

bind adat_lightpipe_tx adat_lightpipe_tx_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .tx_line    (tx_line),
    .word_valid (word_valid),
    .in_ready   (in_ready),
    .act        (seq_active),
    .halt       (seq_halt),
    .mul_x4     (cfg_x4)
);

// File: tb/adat_lightpipe_tx_bench.sv
module adat_lightpipe_tx_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_end = 1'b0;
    logic        in_ready;
    logic [3:0]  user_bits = '0;
    logic        tx_line;
    logic [31:0] word_data;
    logic        word_valid;

    always #4 clk = ~clk;

    adat_lightpipe_tx u_adat_lightpipe_tx (
        .clk        (clk),
        .rst        (rst),
        .in_data    (in_data),
        .in_valid   (in_valid),
        .in_end     (in_end),
        .in_ready   (in_ready),
        .user_bits  (user_bits),
        .tx_line    (tx_line),
        .word_data  (word_data),
        .word_valid (word_valid)
    );

    // Sample table: four groups of eight words; top bytes are junk (R3)
    localparam logic [31:0] STIM [32] = '{
        32'hAA123456, 32'h00FFFFFF, 32'h55000000, 32'h00800001,
        32'hFF7FFFFE, 32'h12A5A5A5, 32'h005A5A5A, 32'hC3000F0F,
        32'h00C0FFEE, 32'h11000001, 32'h22800000, 32'h33ABCDEF,
        32'h44F0F0F0, 32'h550F0F0F, 32'h66135790, 32'h77FEDCBA,
        32'h88000000, 32'h99FFFFFF, 32'h00555555, 32'hEEAAAAAA,
        32'h00246801, 32'hDD987654, 32'h00111111, 32'hBB888888,
        32'h00010203, 32'h01FF00FF, 32'h02C3C3C3, 32'h033C3C3C,
        32'h04700007, 32'h05E00001, 32'h0600FFFF, 32'h07FFFF00
    };

    localparam int MAXREC = 8192;

    int          n_checks = 0;
    int          n_err = 0;
    bit          rec [MAXREC];
    int          nrec = 0;
    bit          rec_on = 1'b0;
    logic [31:0] hist = '0;
    int          wcount = 0;
    int          exp_ids [4];

    function automatic logic [31:0] swap4(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // line monitor and word check (R10)
    always @(negedge clk) begin
        hist = {hist[30:0], tx_line};
        if (rec_on && nrec < MAXREC) begin
            rec[nrec] = tx_line;
            nrec++;
        end
        if (word_valid) begin
            wcount++;
            n_checks++;
            if (word_data !== swap4(hist)) begin
                n_err++;
                $display("FAIL R10: actual %0h expected %0h", word_data, swap4(hist));
            end
        end
    end

    function automatic bit exp_bit(input int g, input logic [3:0] nib, input int k);
        int q, r, grp, ch, gi;
        if (k < 11) return 1'b0;
        if (k == 11) return 1'b1;
        if (k < 16) return nib[15 - k];
        q = k - 16;
        r = q % 5;
        if (r == 0) return 1'b1;
        grp = q / 5;
        ch  = grp / 6;
        gi  = grp % 6;
        return STIM[g*8 + ch][23 - 4*gi - (r - 1)];
    endfunction

    task automatic push(input logic [31:0] d, input bit e);
        @(negedge clk);
        in_data  = d;
        in_valid = 1'b1;
        in_end   = e;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        in_end   = 1'b0;
    endtask

    task automatic push_group(input int g);
        for (int i = 0; i < 8; i++) push(STIM[g*8 + i], 1'b0);
    endtask

    task automatic start_rec();
        @(negedge clk);
        nrec   = 0;
        wcount = 0;
        rec_on = 1'b1;
    endtask

    // decode the NRZI record and compare with expected frames (R3 R4 R7 R11)
    task automatic check_frames(input int nf, input int per, input logic [3:0] nib,
                                input string tag);
        int t0, s, s_end, bad, first_k, toggles;
        t0 = -1;
        for (int i = 1; i < nrec; i++) begin
            if (t0 < 0 && rec[i] != rec[i-1]) t0 = i;
        end
        chk(t0 > 0, {tag, " first toggle"}, t0, 1);
        if (t0 > 0) begin
            for (int f = 0; f < nf; f++) begin
                bad = 0;
                first_k = -1;
                for (int k = 0; k < 256; k++) begin
                    s = t0 + (f*256 + k - 11) * per;
                    if (s < 1 || s >= nrec) begin
                        bad++;
                    end else if ((rec[s] ^ rec[s-1]) != exp_bit(exp_ids[f], nib, k)) begin
                        bad++;
                        if (first_k < 0) first_k = k;
                    end
                end
                chk(bad == 0, {tag, " frame bits"}, first_k, -1);
            end
            s_end = t0 + (nf*256 - 11) * per;
            toggles = 0;
            for (int i = s_end; i < nrec; i++) begin
                if (i > 0 && rec[i] != rec[i-1]) toggles++;
            end
            chk(toggles == 0, "R4 R8 silence after final frame", toggles, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        int toggles;
        repeat (4) @(negedge clk);
        chk(tx_line == 1'b0 && word_valid == 1'b0, "R1 outputs in reset", {tx_line, word_valid}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(tx_line == 1'b0, "R1 tx_line", tx_line, 0);
        chk(word_valid == 1'b0, "R1 word_valid", word_valid, 0);
        chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);

        // Test 1: multiplier 512, no multiplexing, two groups then end
        user_bits = 4'b0110;
        start_rec();
        push(32'd512, 1'b0);
        push(32'd0, 1'b0);
        push_group(0);
        push_group(1);
        @(negedge clk);
        chk(in_ready == 1'b0, "R9 group waiting", in_ready, 0);
        push(32'hDEADBEEF, 1'b1);
        repeat (1500) @(negedge clk);
        rec_on = 1'b0;
        exp_ids[0] = 0;
        exp_ids[1] = 1;
        check_frames(2, 2, 4'b0110, "R3 R7 R11 x2");
        chk(wcount == 32, "R10 word count", wcount, 32);
        chk(in_ready == 1'b1, "R8 ready after stop", in_ready, 1);

        // Test 2: end marker before a full group
        user_bits = 4'b0000;
        start_rec();
        push(32'd512, 1'b0);
        push(32'd0, 1'b0);
        for (int i = 0; i < 3; i++) push(STIM[i], 1'b0);
        push(32'h0, 1'b1);
        repeat (600) @(negedge clk);
        rec_on = 1'b0;
        toggles = 0;
        for (int i = 1; i < nrec; i++) if (rec[i] != rec[i-1]) toggles++;
        chk(toggles == 0, "R5 no frame from partial group", toggles, 0);
        chk(wcount == 0, "R5 no words", wcount, 0);
        chk(in_ready == 1'b1, "R8 early end returns to config", in_ready, 1);

        // Test 3: multiplier 1024, multiplexing on, starved boundary repeats
        user_bits = 4'b1001;
        start_rec();
        push(32'd1024, 1'b0);
        push(32'd2, 1'b0);
        push_group(2);
        repeat (1600) @(negedge clk);
        push_group(3);
        push(32'h0, 1'b1);
        repeat (1500) @(negedge clk);
        rec_on = 1'b0;
        exp_ids[0] = 2;
        exp_ids[1] = 2;
        exp_ids[2] = 3;
        check_frames(3, 4, 4'b1011, "R2 R6 R7 x4");
        chk(wcount == 96, "R10 word count x4", wcount, 96);

        // Test 4: unlisted multiplier falls back to 2 clocks per bit
        user_bits = 4'b1111;
        start_rec();
        push(32'd300, 1'b0);
        push(32'd5, 1'b0);
        push_group(1);
        push(32'h0, 1'b1);
        repeat (800) @(negedge clk);
        rec_on = 1'b0;
        exp_ids[0] = 1;
        check_frames(1, 2, 4'b1111, "R2 fallback");
        chk(wcount == 16, "R10 word count fallback", wcount, 16);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule